// File: doc/BRIEF.md
# Countdown Watchdog with Early-Warning Interrupt

This block is a memory-mapped watchdog. Software loads a 16-bit tick count and sets a run bit. While the watchdog runs, the count drops by one on every coarse tick. A prescaler derives the tick from the system clock, and a parameter can swap the prescaler for an external tick-enable input. Each write of a new count acts as the keepalive, and no key value is needed. Reading the count returns the ticks that remain before expiry.

With the early-warning option set, a non-maskable interrupt request is raised when the count falls to a fixed lead value (by default 70 ticks, about 9 s at 128 ms per tick). Two status bits tell the interrupt handler that the request came from this block. If the count reaches zero while the watchdog runs, the block pulses its reset output for one cycle and clears the run bit.

The register window is halfword-addressed. Status is at offset 0x6E, the count is at 0x70 and control is at 0x72. These offsets are fixed because driver software decodes them.

Top module: `wdog_pretimer`

## Requirements
- R1: After reset the count, control and status registers read 0, and both `nmi_req` and `wdt_reset` are low.
- R2: A write to offset 0x70 with both byte lanes enabled (`bus_be` = 2'b11) loads the count. A read of 0x70 returns the current count. A write with only one byte lane enabled leaves the count unchanged.
- R3: The control register at 0x72 is written through byte lane 0 and reads back all 8 bits in `bus_rdata[7:0]`. Bit 0 is run and bit 2 is the early-warning enable. A write through byte lane 1 alone has no effect.
- R4: While run is set, the count drops by one every TICK_CYCLES clock cycles. A reload or a start restarts the prescaler, so the first decrement comes TICK_CYCLES cycles after that write. While run is clear, the count holds its value.
- R5: If run is set and the count is 0, `wdt_reset` goes high for exactly one cycle, control bit 0 clears, the other control bits keep their values, and status bit 2 sets. A reload of N ticks on a running watchdog gives the pulse TICK_CYCLES*N+1 cycles after the write edge.
- R6: With run and bit 2 set, the tick that moves the count from PRE_LEAD+1 to PRE_LEAD raises `nmi_req` and status bit 1. Both stay set, even through expiry, until a count reload or a control write with bit 0 clear. Either action clears status bits 1 and 2.
- R7: A count loaded at or below PRE_LEAD never raises `nmi_req` before expiry.
- R8: The status register at 0x6E is read-only, so writes to it are ignored. A read of any offset other than 0x6E, 0x70 and 0x72 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 7 | Byte offset within the 0x80 window |
| bus_be | input | 2 | Byte-lane enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| ext_tick | input | 1 | External tick enable, used when USE_EXT_TICK = 1 |
| nmi_req | output | 1 | Early-warning interrupt request, held as a level |
| wdt_reset | output | 1 | One-cycle system reset pulse on expiry |

## Verification
A wrong count value shows up at once at the 0x70 read port. It also moves the reset pulse away from its computed cycle, TICK_CYCLES*N+1 after the reload. A prescaler that does not restart on a reload shifts that cycle by up to TICK_CYCLES-1, so the bench measures every expiry against an exact cycle number. A lost or stuck early-warning flag shows up as `nmi_req` missing at the single predicted edge, or still high in the cycle after a reload or stop. The status byte read back at that point confirms it.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
   localparam int BUS_W  = 16;
   localparam int ADDR_W = 7;

   localparam logic [ADDR_W-1:0] OFF_STAT = 7'h6E;
   localparam logic [ADDR_W-1:0] OFF_CNT  = 7'h70;
   localparam logic [ADDR_W-1:0] OFF_CTL  = 7'h72;

   localparam int CTL_RUN  = 0;
   localparam int CTL_PRE  = 2;
   localparam int STAT_PRE = 1;
   localparam int STAT_EXP = 2;
endpackage

// File: rtl/wdp_prescaler.sv
module wdp_prescaler #(
   parameter int TICK_CYCLES  = 16_000_000,
   parameter bit USE_EXT_TICK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic ext_tick,
   output logic tick
);
   localparam int PSC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(TICK_CYCLES - 1);

   generate
      if (USE_EXT_TICK) begin : g_ext
         assign tick = run & ext_tick & ~restart;
      end else begin : g_div
         logic [PSC_W-1:0] psc_q;
         logic             unused_ext;
         assign unused_ext = ext_tick;
         assign tick = run & ~restart & (psc_q == PSC_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              psc_q <= '0;
            else if (!run || restart) psc_q <= '0;
            else if (tick)            psc_q <= '0;
            else                      psc_q <= psc_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wdp_countdown.sv
module wdp_countdown #(
   parameter int CNT_W    = 16,
   parameter int PRE_LEAD = 70
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             pre_en,
   output logic [CNT_W-1:0] cnt,
   output logic             at_zero,
   output logic             pre_hit
);
   localparam logic [CNT_W-1:0] PRE_ARM = CNT_W'(PRE_LEAD + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign at_zero = (cnt == '0);
   assign pre_hit = tick & ~load & pre_en & (cnt == PRE_ARM);
endmodule

// File: rtl/wdp_regs.sv
module wdp_regs
   import wdp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              at_zero,
   input  logic              pre_hit,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              run,
   output logic              pre_en,
   output logic              nmi_req,
   output logic              wdt_reset
);
   logic [7:0] ctl_q;
   logic       pre_flag_q, exp_flag_q, rst_q;
   logic       wr_ctl, expire, flag_clr;
   logic [7:0] stat_byte;

   assign load     = bus_wr && (bus_addr == OFF_CNT) && (bus_be == 2'b11);
   assign load_val = bus_wdata[CNT_W-1:0];
   assign wr_ctl   = bus_wr && (bus_addr == OFF_CTL) && bus_be[0];
   assign run      = ctl_q[CTL_RUN];
   assign pre_en   = ctl_q[CTL_PRE];
   assign expire   = run & at_zero;
   assign flag_clr = load | (wr_ctl & ~bus_wdata[CTL_RUN]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         pre_flag_q <= 1'b0;
         exp_flag_q <= 1'b0;
         rst_q      <= 1'b0;
      end else begin
         rst_q <= expire;
         if (wr_ctl)      ctl_q <= bus_wdata[7:0];
         else if (expire) ctl_q[CTL_RUN] <= 1'b0;
         if (flag_clr) begin
            pre_flag_q <= 1'b0;
            exp_flag_q <= 1'b0;
         end else begin
            if (pre_hit) pre_flag_q <= 1'b1;
            if (expire)  exp_flag_q <= 1'b1;
         end
      end
   end

   always_comb begin
      stat_byte           = '0;
      stat_byte[STAT_PRE] = pre_flag_q;
      stat_byte[STAT_EXP] = exp_flag_q;
   end

   always_comb begin
      unique case (bus_addr)
         OFF_STAT: bus_rdata = {8'h00, stat_byte};
         OFF_CNT:  bus_rdata = BUS_W'(cnt);
         OFF_CTL:  bus_rdata = {8'h00, ctl_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign nmi_req   = pre_flag_q;
   assign wdt_reset = rst_q;
endmodule

// File: rtl/wdog_pretimer.sv
module wdog_pretimer
   import wdp_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int TICK_CYCLES  = 16_000_000,
   parameter int PRE_LEAD     = 70,
   parameter bit USE_EXT_TICK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              ext_tick,
   output logic              nmi_req,
   output logic              wdt_reset
);
   generate
      if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_width
         $error("CNT_W must lie between 8 and the bus width");
      end
      if (TICK_CYCLES < 1) begin : g_bad_div
         $error("TICK_CYCLES must be at least 1");
      end
      if (PRE_LEAD < 1 || PRE_LEAD + 1 >= (1 << CNT_W)) begin : g_bad_lead
         $error("PRE_LEAD must fit below the largest count");
      end
   endgenerate

   logic             tick, load, run, pre_en, at_zero, pre_hit;
   logic [CNT_W-1:0] load_val, cnt;

   wdp_prescaler #(.TICK_CYCLES(TICK_CYCLES), .USE_EXT_TICK(USE_EXT_TICK)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(load),
      .ext_tick(ext_tick), .tick(tick));

   wdp_countdown #(.CNT_W(CNT_W), .PRE_LEAD(PRE_LEAD)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(load_val),
      .pre_en(pre_en), .cnt(cnt), .at_zero(at_zero), .pre_hit(pre_hit));

   wdp_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .at_zero(at_zero), .pre_hit(pre_hit), .load(load),
      .load_val(load_val), .run(run), .pre_en(pre_en),
      .nmi_req(nmi_req), .wdt_reset(wdt_reset));
endmodule

// File: rtl/wdp_checker.sv
module wdp_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic             run,
   input logic             pre_en,
   input logic [CNT_W-1:0] cnt,
   input logic             nmi_req,
   input logic             wdt_reset
);
   a_r5_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |=> !wdt_reset);

   a_r5_run_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset |-> !run);

   a_r6_reload_clears_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !nmi_req);

   a_r6_nmi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> (pre_en && run));

   a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt));

   a_r4_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt <= $past(cnt)));
endmodule

bind wdog_pretimer wdp_checker #(.CNT_W(CNT_W)) u_wdp_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .run(run), .pre_en(pre_en),
   .cnt(cnt), .nmi_req(nmi_req), .wdt_reset(wdt_reset));

// File: tb/wdog_pretimer_bench.sv
module wdog_pretimer_bench;
   localparam int TC   = 4;
   localparam int LEAD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        nmi_req, wdt_reset;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   int mark  = 0;
   int exp_q[$];
   bit done  = 1'b0;

   always #4 clk = ~clk;

   wdog_pretimer #(.CNT_W(16), .TICK_CYCLES(TC), .PRE_LEAD(LEAD), .USE_EXT_TICK(1'b0)) u_wdog_pretimer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_tick(1'b0), .nmi_req(nmi_req), .wdt_reset(wdt_reset));

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops the expected cycle of each reset pulse
   always @(negedge clk) begin
      if (rst_n && wdt_reset) begin
         if (exp_q.size() == 0) check("R5 unexpected pulse", 16'(cyc), 16'hFFFF);
         else check("R5 pulse cycle", 16'(cyc), 16'(exp_q.pop_front()));
      end
   end

   task automatic wr(input logic [6:0] a, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
      mark = cyc;
   endtask

   task automatic rd(input logic [6:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic expect_rst(input int n);
      exp_q.push_back(mark + TC * n + 1);
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(7'h70, v); check("R1 count", v, 16'h0000);
      rd(7'h72, v); check("R1 control", v, 16'h0000);
      rd(7'h6E, v); check("R1 status", v, 16'h0000);
      check("R1 nmi", {15'd0, nmi_req}, 16'd0);
      check("R1 reset out", {15'd0, wdt_reset}, 16'd0);

      // R2 load, partial write ignored
      wr(7'h70, 2'b11, 16'h1234);
      rd(7'h70, v); check("R2 load", v, 16'h1234);
      wr(7'h70, 2'b01, 16'h00FF);
      rd(7'h70, v); check("R2 partial write", v, 16'h1234);
      // R3 upper lane alone ignored
      wr(7'h72, 2'b10, 16'hFFFF);
      rd(7'h72, v); check("R3 upper lane", v, 16'h0000);
      // R8 status read-only, unmapped reads 0
      wr(7'h6E, 2'b11, 16'hFFFF);
      rd(7'h6E, v); check("R8 status write", v, 16'h0000);
      rd(7'h10, v); check("R8 unmapped", v, 16'h0000);
      // R4 stopped holds
      wait_edges(20);
      rd(7'h70, v); check("R4 stopped hold", v, 16'h1234);

      // R4/R5 running countdown and expiry
      wr(7'h70, 2'b11, 16'd10);
      wr(7'h72, 2'b01, 16'h0081);
      rd(7'h72, v); check("R3 control readback", v, 16'h0081);
      wr(7'h70, 2'b11, 16'd10);
      expect_rst(10);
      wait_edges(3);
      rd(7'h70, v); check("R4 before first tick", v, 16'd10);
      wait_edges(5);
      rd(7'h70, v); check("R4 rate", v, 16'd8);
      wait_edges(34);
      rd(7'h72, v); check("R5 run cleared", v, 16'h0080);
      rd(7'h6E, v); check("R5 status expiry", v, 16'h0004);
      rd(7'h70, v); check("R5 count zero", v, 16'd0);

      // R6 early warning
      wr(7'h70, 2'b11, 16'd10);
      rd(7'h6E, v); check("R6 reload clears status", v, 16'h0000);
      wr(7'h72, 2'b01, 16'h0085);
      wait_edges(27);
      check("R6 nmi not early", {15'd0, nmi_req}, 16'd0);
      wait_edges(1);
      check("R6 nmi raised", {15'd0, nmi_req}, 16'd1);
      rd(7'h6E, v); check("R6 status bit", v, 16'h0002);
      rd(7'h70, v); check("R6 lead count", v, 16'd3);
      wr(7'h70, 2'b11, 16'd10);
      check("R6 reload clears nmi", {15'd0, nmi_req}, 16'd0);
      wait_edges(28);
      check("R6 nmi again", {15'd0, nmi_req}, 16'd1);
      wr(7'h72, 2'b01, 16'h0084);
      check("R6 stop clears nmi", {15'd0, nmi_req}, 16'd0);
      rd(7'h6E, v); check("R6 stop clears status", v, 16'h0000);
      rd(7'h70, v); v = v;
      wait_edges(12);
      rd(7'h70, v); check("R4 hold after stop", v, 16'd3);

      // R7 load at lead: no nmi before expiry
      wr(7'h72, 2'b01, 16'h0085);
      expect_rst(3);
      seen = 1'b0;
      for (int i = 0; i < 14; i++) begin
         wait_edges(1);
         if (nmi_req) seen = 1'b1;
      end
      check("R7 no nmi", {15'd0, seen}, 16'd0);
      rd(7'h6E, v); check("R7 status", v, 16'h0004);

      // R5/R6 expiry with warning pending
      wr(7'h70, 2'b11, 16'd5);
      wr(7'h72, 2'b01, 16'h0085);
      expect_rst(5);
      wait_edges(8);
      check("R6 nmi at lead", {15'd0, nmi_req}, 16'd1);
      wait_edges(14);
      rd(7'h6E, v); check("R6 flags through expiry", v, 16'h0006);
      check("R6 nmi held after expiry", {15'd0, nmi_req}, 16'd1);
      rd(7'h72, v); check("R5 other bits kept", v, 16'h0084);
      wr(7'h72, 2'b01, 16'h0000);
      check("R6 stop write clears", {15'd0, nmi_req}, 16'd0);
      rd(7'h6E, v); check("R6 status cleared", v, 16'h0000);

      wait_edges(4);
      check("R5 all pulses seen", 16'(exp_q.size()), 16'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule